// File: doc/BRIEF.md
# Descriptor Ring Register Bank

This block holds the software-visible control state of a set of DMA descriptor rings and decodes the register windows through which that state is written and read. The set always contains one command ring, one event ring, and a transmit ring plus a receive ring for each front-panel port. Every ring keeps a 64-bit base address, a size, a head index written by software, a tail index advanced by the data path, a control word and a count of outstanding credits.

Software writes land in one window per ring, picked out of the address. A head write that moves the head, or a credit write that returns credits, produces a one-cycle pulse for that ring and may raise an interrupt request tagged with the ring's vector. The data path reports each completed descriptor through a per-ring post strobe, which advances the tail and adds a credit. A small combinational query port turns a ring index into its role, port and vector, and a port number into its transmit and receive ring indices.

Top module: `dring_regbank`

## Requirements
- R1: A ring window is 32 bytes. An address hits ring k when it lies in [WIN_BASE, WIN_BASE + 32 × ring count), with k = (address − WIN_BASE) / 32 and the window offset being the low five bits. Writes outside this range change nothing, and reads there return zero.
- R2: With ring count = 2 + 2 × NUM_PORTS, index 0 is the command ring (role code 0) and index 1 is the event ring (role 1). From index 2 on, even indices are transmit rings (role 2) and odd indices are receive rings (role 3). The 1-based port of ring k ≥ 2 is (k − 2)/2 + 1, and 0 for the command and event rings. For port p in 1..NUM_PORTS the transmit index is (p − 1)·2 + 2 and the receive index is (p − 1)·2 + 3, and both are 0 for other p. Indices at or above the ring count report role 0, port 0, vector 0.
- R3: The vectors are 0 for the command ring and 1 for the event ring. For the zero-based port n, the transmit ring uses 2 + 2n and the receive ring uses 3 + 2n. Every ring interrupt carries its own ring's vector.
- R4: A 32-bit write at offset 0x00 only loads a low-half latch that all rings share. A 32-bit write at 0x04 sets the base to {data, latch} and clears the latch. A 64-bit write at 0x00 loads the whole base. 32-bit reads at 0x00 and 0x04 return the low and high halves, and a 64-bit read at 0x00 returns all 64 bits.
- R5: The size at offset 0x08 is readable and writable. The control word at 0x14 is write-only: it drives the ring's slice of `ring_ctrl` and reads as zero.
- R6: A 32-bit head write at 0x0C whose value is below the ring size updates the head. In the next cycle it raises that ring's `head_pulse` bit and `irq_req` with the ring's vector. A value at or above the size leaves the head unchanged and produces no pulse and no interrupt.
- R7: A 32-bit write at 0x18 subtracts the written count from the credits, saturating at zero. It pulses the ring's `cred_pulse` bit in the next cycle and raises `irq_req` only if credits remain afterwards.
- R8: Each `ring_post` bit advances that ring's tail by one, wrapping to 0 when it reaches the size (the tail stays 0 while the size is 0). The post also adds one credit, saturating at 2^CRED_W − 1. The tail, read at 0x10, ignores writes.
- R9: Reads return data with `rd_valid` one cycle after `rd_en`. The upper 32 bits of a 32-bit read are zero, and unused offsets, plus 64-bit reads at any offset other than 0x00, return zero.
- R10: A synchronous active-low reset clears every base, size, head, tail, credit and control field, the low-half latch, all pulses and the interrupt request.
- R11: A 64-bit write at any offset other than 0x00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data (low 32 bits used by 32-bit writes) |
| rd_en | input | 1 | Read strobe |
| rd_wide | input | 1 | 1 = 64-bit read, 0 = 32-bit read |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 64 | Read data |
| ring_post | input | RING_CNT | Per-ring descriptor completion strobe |
| head_pulse | output | RING_CNT | Per-ring accepted head write pulse |
| cred_pulse | output | RING_CNT | Per-ring credit return pulse |
| irq_req | output | 1 | Interrupt request pulse |
| irq_vec | output | IDX_W | Vector of the requesting ring |
| ring_ctrl | output | RING_CNT×CTRL_W | Control words of all rings, ring 0 in the low bits |
| map_idx | input | IDX_W | Query: ring index |
| map_role | output | 2 | Role code of map_idx |
| map_port | output | PORT_W | 1-based port of map_idx |
| map_vec | output | IDX_W | Vector of map_idx |
| map_pnum | input | PORT_W | Query: 1-based port number |
| map_tx_idx | output | IDX_W | Transmit ring index of map_pnum |
| map_rx_idx | output | IDX_W | Receive ring index of map_pnum |

## Verification
The bench goes after the edges of the window space. Writes just above the last window must not alias onto ring 0, which a decoder with a short index field or a missing upper bound check would do. It checks a head write equal to the size, which an off-by-one compare would take as legal and then pulse and interrupt for. Credit returns larger than the balance must clamp at zero and stay quiet: wrapping arithmetic would leave a huge balance and raise a spurious interrupt. Tail wrap at the size, credit saturation under long post bursts, and a shared low-half latch that must clear after each high-half commit are all swept over every ring, so a design that mixes up ring indices or vectors shows up in the map and interrupt checks.

// File: rtl/dring_pkg.sv
// Package: window offsets, ring roles and the index arithmetic that maps a
// ring index to its role, port and interrupt vector. Assumes rings are
// ordered command, event, then a transmit/receive pair per port.
package dring_pkg;

    localparam int OFF_BASE_LO = 0;
    localparam int OFF_BASE_HI = 4;
    localparam int OFF_SIZE    = 8;
    localparam int OFF_HEAD    = 12;
    localparam int OFF_TAIL    = 16;
    localparam int OFF_CTRL    = 20;
    localparam int OFF_CRED    = 24;

    typedef enum logic [1:0] {
        ROLE_CMD = 2'd0,
        ROLE_EVT = 2'd1,
        ROLE_TX  = 2'd2,
        ROLE_RX  = 2'd3
    } ring_role_e;

    // Role of ring idx (idx assumed below the ring count).
    function automatic ring_role_e role_of(int idx);
        if (idx == 0)          return ROLE_CMD;
        else if (idx == 1)     return ROLE_EVT;
        else if (idx % 2 == 0) return ROLE_TX;
        else                   return ROLE_RX;
    endfunction

    // 1-based port of ring idx, 0 for the command and event rings.
    function automatic int port_of(int idx);
        if (idx < 2) return 0;
        return (idx - 2) / 2 + 1;
    endfunction

    // Interrupt vector of ring idx.
    function automatic int vec_of(int idx);
        int n;
        if (idx < 2) return idx;
        n = port_of(idx) - 1;
        if (role_of(idx) == ROLE_TX) return 2 + 2 * n;
        return 3 + 2 * n;
    endfunction

    function automatic int tx_index_of(int p);
        return (p - 1) * 2 + 2;
    endfunction

    function automatic int rx_index_of(int p);
        return (p - 1) * 2 + 3;
    endfunction

endpackage

// File: rtl/dring_addr_decode.sv
// Address decoder: splits a byte address into an in-space flag, a ring
// index and a window offset. Assumes windows of 2**WIN_SHIFT bytes packed
// back to back from WIN_BASE.
module dring_addr_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BASE  = 16'h1000,
    parameter int unsigned WIN_SHIFT = 5,
    parameter int unsigned RING_CNT  = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [WIN_SHIFT-1:0] off
);
    localparam logic [ADDR_W:0] LO_BOUND = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] HI_BOUND = (ADDR_W+1)'(WIN_BASE + (RING_CNT << WIN_SHIFT));

    logic [ADDR_W-1:0] rel;

    // Range check and window split.
    always_comb begin
        rel = addr - ADDR_W'(WIN_BASE);
        hit = ({1'b0, addr} >= LO_BOUND) && ({1'b0, addr} < HI_BOUND);
        idx = IDX_W'(rel >> WIN_SHIFT);
        off = rel[WIN_SHIFT-1:0];
    end
endmodule

// File: rtl/dring_role_map.sv
// Role map: combinational query of role, port and vector for a ring index,
// and of the transmit/receive indices for a port. Out-of-range queries
// report zeros.
module dring_role_map
    import dring_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned RING_CNT  = 6,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned PORT_W    = 2
) (
    input  logic [IDX_W-1:0]  q_idx,
    input  logic [PORT_W-1:0] q_port,
    output logic [1:0]        role,
    output logic [PORT_W-1:0] port,
    output logic [IDX_W-1:0]  vec,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [IDX_W-1:0]  rx_idx
);
    // Index to role/port/vector.
    always_comb begin
        if (int'(q_idx) < int'(RING_CNT)) begin
            role = role_of(int'(q_idx));
            port = PORT_W'(port_of(int'(q_idx)));
            vec  = IDX_W'(vec_of(int'(q_idx)));
        end else begin
            role = 2'd0;
            port = '0;
            vec  = '0;
        end
    end

    // Port to ring indices.
    always_comb begin
        if (q_port != '0 && int'(q_port) <= int'(NUM_PORTS)) begin
            tx_idx = IDX_W'(tx_index_of(int'(q_port)));
            rx_idx = IDX_W'(rx_index_of(int'(q_port)));
        end else begin
            tx_idx = '0;
            rx_idx = '0;
        end
    end
endmodule

// File: rtl/dring_slot.sv
// One ring's state: base, size, head, tail, credits and control. Applies
// window writes selected by the top and post strobes from the data path.
// Assumes at most one write per cycle and SIZE_W, CRED_W no wider than 32.
module dring_slot
    import dring_pkg::*;
#(
    parameter int unsigned SIZE_W = 16,
    parameter int unsigned CRED_W = 16,
    parameter int unsigned CTRL_W = 8,
    parameter int unsigned OFF_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              wr_wide,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [63:0]       wr_data,
    input  logic [31:0]       lo_latch,
    input  logic              post,
    output logic [63:0]       base_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [SIZE_W-1:0] head_o,
    output logic [SIZE_W-1:0] tail_o,
    output logic [CRED_W-1:0] cred_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              head_evt,
    output logic              cred_evt,
    output logic              cred_irq
);
    logic [63:0]       base_q;
    logic [SIZE_W-1:0] size_q, head_q, tail_q, tail_nxt;
    logic [CRED_W-1:0] cred_q, cred_nxt, cred_cap;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CRED_W:0]   cred_sum;
    logic [SIZE_W:0]   tail_inc;
    logic              w32;

    // Write qualification for head and credit accesses.
    always_comb begin
        w32      = wr_sel && !wr_wide;
        head_evt = w32 && (wr_off == OFF_W'(OFF_HEAD)) && (wr_data[31:0] < 32'(size_q));
        cred_evt = w32 && (wr_off == OFF_W'(OFF_CRED));
    end

    // Credit arithmetic: add the post first, then subtract a return.
    always_comb begin
        cred_sum = {1'b0, cred_q} + (CRED_W+1)'(post);
        cred_cap = cred_sum[CRED_W] ? {CRED_W{1'b1}} : cred_sum[CRED_W-1:0];
        if (cred_evt) begin
            if (wr_data[31:0] >= 32'(cred_cap)) cred_nxt = '0;
            else                                 cred_nxt = cred_cap - CRED_W'(wr_data[31:0]);
        end else begin
            cred_nxt = cred_cap;
        end
        cred_irq = cred_evt && (cred_nxt != '0);
    end

    // Tail advance with wrap at the ring size.
    always_comb begin
        tail_inc = {1'b0, tail_q} + (SIZE_W+1)'(1);
        if (!post)                          tail_nxt = tail_q;
        else if (tail_inc >= {1'b0, size_q}) tail_nxt = '0;
        else                                 tail_nxt = tail_inc[SIZE_W-1:0];
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            cred_q <= '0;
            ctrl_q <= '0;
        end else begin
            tail_q <= tail_nxt;
            cred_q <= cred_nxt;
            if (wr_sel && wr_wide) begin
                if (wr_off == OFF_W'(OFF_BASE_LO)) base_q <= wr_data;
            end else if (wr_sel) begin
                if (wr_off == OFF_W'(OFF_BASE_HI)) base_q <= {wr_data[31:0], lo_latch};
                if (wr_off == OFF_W'(OFF_SIZE))    size_q <= wr_data[SIZE_W-1:0];
                if (wr_off == OFF_W'(OFF_CTRL))    ctrl_q <= wr_data[CTRL_W-1:0];
            end
            if (head_evt) head_q <= wr_data[SIZE_W-1:0];
        end
    end

    assign base_o = base_q;
    assign size_o = size_q;
    assign head_o = head_q;
    assign tail_o = tail_q;
    assign cred_o = cred_q;
    assign ctrl_o = ctrl_q;

    // R6: head moves only on an accepted head write.
    p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !head_evt |=> $stable(head_q));
    // R6: an accepted head lies below the size.
    p_head_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        head_evt |=> head_q < size_q);
    // R8: tail moves only on a post.
    p_tail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !post |=> $stable(tail_q));
    // R7: without a post, credits never rise.
    p_cred_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !post |=> cred_q <= $past(cred_q));
endmodule

// File: rtl/dring_regbank.sv
// Descriptor ring register bank top: decodes write and read addresses into
// ring windows, holds the shared low-half latch, instantiates one slot per
// ring, registers pulses and the interrupt request, and muxes read data.
// Assumes one write and one read per cycle at most.
module dring_regbank
    import dring_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BASE  = 16'h1000,
    parameter int unsigned SIZE_W    = 16,
    parameter int unsigned CRED_W    = 16,
    parameter int unsigned CTRL_W    = 8,
    localparam int unsigned WIN_SHIFT = 5,
    localparam int unsigned RING_CNT  = 2 + 2 * NUM_PORTS,
    localparam int unsigned IDX_W     = $clog2(RING_CNT),
    localparam int unsigned PORT_W    = $clog2(NUM_PORTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_wide,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [63:0]                  wr_data,
    input  logic                         rd_en,
    input  logic                         rd_wide,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic                         rd_valid,
    output logic [63:0]                  rd_data,
    input  logic [RING_CNT-1:0]          ring_post,
    output logic [RING_CNT-1:0]          head_pulse,
    output logic [RING_CNT-1:0]          cred_pulse,
    output logic                         irq_req,
    output logic [IDX_W-1:0]             irq_vec,
    output logic [RING_CNT*CTRL_W-1:0]   ring_ctrl,
    input  logic [IDX_W-1:0]             map_idx,
    output logic [1:0]                   map_role,
    output logic [PORT_W-1:0]            map_port,
    output logic [IDX_W-1:0]             map_vec,
    input  logic [PORT_W-1:0]            map_pnum,
    output logic [IDX_W-1:0]             map_tx_idx,
    output logic [IDX_W-1:0]             map_rx_idx
);
    logic                 wr_hit, rd_hit;
    logic [IDX_W-1:0]     wr_idx, rd_idx;
    logic [WIN_SHIFT-1:0] wr_off, rd_off;
    logic [31:0]          lo_latch_q;
    logic [RING_CNT-1:0]  head_evt_v, cred_evt_v, cred_irq_v;
    logic [63:0]          rd_word;

    logic [63:0]       base_a [RING_CNT];
    logic [SIZE_W-1:0] size_a [RING_CNT];
    logic [SIZE_W-1:0] head_a [RING_CNT];
    logic [SIZE_W-1:0] tail_a [RING_CNT];
    logic [CRED_W-1:0] cred_a [RING_CNT];

    dring_addr_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SHIFT(WIN_SHIFT),
        .RING_CNT(RING_CNT), .IDX_W(IDX_W)
    ) u_wr_dec (.addr(wr_addr), .hit(wr_hit), .idx(wr_idx), .off(wr_off));

    dring_addr_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SHIFT(WIN_SHIFT),
        .RING_CNT(RING_CNT), .IDX_W(IDX_W)
    ) u_rd_dec (.addr(rd_addr), .hit(rd_hit), .idx(rd_idx), .off(rd_off));

    dring_role_map #(
        .NUM_PORTS(NUM_PORTS), .RING_CNT(RING_CNT), .IDX_W(IDX_W), .PORT_W(PORT_W)
    ) u_map (
        .q_idx(map_idx), .q_port(map_pnum), .role(map_role), .port(map_port),
        .vec(map_vec), .tx_idx(map_tx_idx), .rx_idx(map_rx_idx)
    );

    for (genvar g = 0; g < RING_CNT; g++) begin : g_slot
        dring_slot #(
            .SIZE_W(SIZE_W), .CRED_W(CRED_W), .CTRL_W(CTRL_W), .OFF_W(WIN_SHIFT)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_sel(wr_en && wr_hit && (wr_idx == IDX_W'(g))),
            .wr_wide(wr_wide), .wr_off(wr_off), .wr_data(wr_data),
            .lo_latch(lo_latch_q), .post(ring_post[g]),
            .base_o(base_a[g]), .size_o(size_a[g]), .head_o(head_a[g]),
            .tail_o(tail_a[g]), .cred_o(cred_a[g]),
            .ctrl_o(ring_ctrl[g*CTRL_W +: CTRL_W]),
            .head_evt(head_evt_v[g]), .cred_evt(cred_evt_v[g]), .cred_irq(cred_irq_v[g])
        );
    end

    // Shared low-half latch for split base writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_latch_q <= '0;
        end else if (wr_en && wr_hit && !wr_wide) begin
            if (wr_off == WIN_SHIFT'(OFF_BASE_LO))      lo_latch_q <= wr_data[31:0];
            else if (wr_off == WIN_SHIFT'(OFF_BASE_HI)) lo_latch_q <= '0;
        end
    end

    // Notification pulses and interrupt request, one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_pulse <= '0;
            cred_pulse <= '0;
            irq_req    <= 1'b0;
            irq_vec    <= '0;
        end else begin
            head_pulse <= head_evt_v;
            cred_pulse <= cred_evt_v;
            irq_req    <= |(head_evt_v | cred_irq_v);
            irq_vec    <= IDX_W'(vec_of(int'(wr_idx)));
        end
    end

    // Read data selection by window offset and access width.
    always_comb begin
        rd_word = '0;
        if (rd_hit) begin
            if (rd_wide) begin
                if (rd_off == WIN_SHIFT'(OFF_BASE_LO)) rd_word = base_a[rd_idx];
            end else begin
                case (rd_off)
                    WIN_SHIFT'(OFF_BASE_LO): rd_word = {32'd0, base_a[rd_idx][31:0]};
                    WIN_SHIFT'(OFF_BASE_HI): rd_word = {32'd0, base_a[rd_idx][63:32]};
                    WIN_SHIFT'(OFF_SIZE):    rd_word = 64'(size_a[rd_idx]);
                    WIN_SHIFT'(OFF_HEAD):    rd_word = 64'(head_a[rd_idx]);
                    WIN_SHIFT'(OFF_TAIL):    rd_word = 64'(tail_a[rd_idx]);
                    WIN_SHIFT'(OFF_CRED):    rd_word = 64'(cred_a[rd_idx]);
                    default:                 rd_word = '0;
                endcase
            end
        end
    end

    // Read data register, one cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_word;
        end
    end

    // R9: read data follows a read strobe by one cycle.
    p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));
    // R3: requested vector names an existing ring.
    p_irq_vec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> int'(irq_vec) < int'(RING_CNT));
    // R7: an interrupt always comes with a head or credit pulse.
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (|(head_pulse | cred_pulse)));
    // R6: at most one ring is notified per cycle.
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(head_pulse | cred_pulse));
endmodule

// File: tb/test_dring_regbank.sv
module test_dring_regbank;
    localparam int NP      = 2;
    localparam int RC      = 2 + 2 * NP;
    localparam int IW      = 3;
    localparam int PW      = 2;
    localparam int AW      = 16;
    localparam int WBASE   = 16'h1000;
    localparam int CW      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_wide = 1'b0, rd_en = 1'b0, rd_wide = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [63:0] wr_data = '0;
    logic rd_valid;
    logic [63:0] rd_data;
    logic [RC-1:0] ring_post = '0;
    logic [RC-1:0] head_pulse, cred_pulse;
    logic irq_req;
    logic [IW-1:0] irq_vec;
    logic [RC*8-1:0] ring_ctrl;
    logic [IW-1:0] map_idx = '0;
    logic [1:0] map_role;
    logic [PW-1:0] map_port;
    logic [IW-1:0] map_vec;
    logic [PW-1:0] map_pnum = '0;
    logic [IW-1:0] map_tx_idx, map_rx_idx;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dring_regbank #(.NUM_PORTS(NP), .ADDR_W(AW), .WIN_BASE(WBASE), .CRED_W(CW)) i_dring_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_wide(rd_wide), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .ring_post(ring_post),
        .head_pulse(head_pulse), .cred_pulse(cred_pulse), .irq_req(irq_req), .irq_vec(irq_vec),
        .ring_ctrl(ring_ctrl), .map_idx(map_idx), .map_role(map_role), .map_port(map_port),
        .map_vec(map_vec), .map_pnum(map_pnum), .map_tx_idx(map_tx_idx), .map_rx_idx(map_rx_idx)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] adr(int r, int off);
        return AW'(WBASE + r * 32 + off);
    endfunction

    function automatic int exp_vec(int r);
        if (r < 2) return r;
        if (r % 2 == 0) return 2 + 2 * ((r - 2) / 2);
        return 3 + 2 * ((r - 2) / 2);
    endfunction

    // Write, returning at the negedge where registered pulses are visible.
    task automatic wr(logic [AW-1:0] a, logic [63:0] d, logic wide);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_wide = wide;
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic wide, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; rd_wide = wide;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 rd_valid", 64'(rd_valid), 64'd1);
        d = rd_data;
    endtask

    task automatic post(logic [RC-1:0] m, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ring_post = m;
            @(negedge clk); ring_post = '0;
        end
    endtask

    initial begin
        #600000;
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 irq", 64'(irq_req), 0);
        check("R10 pulses", 64'({head_pulse, cred_pulse}), 0);
        check("R10 ctrl", 64'(ring_ctrl), 0);
        for (int r = 0; r < RC; r++) begin
            rd(adr(r, 0), 1'b1, v); check("R10 base", v, 0);
            rd(adr(r, 8), 1'b0, v); check("R10 size", v, 0);
            rd(adr(r, 12), 1'b0, v); check("R10 head", v, 0);
            rd(adr(r, 16), 1'b0, v); check("R10 tail", v, 0);
            rd(adr(r, 24), 1'b0, v); check("R10 cred", v, 0);
        end

        // R2 / R3: role map sweep
        for (int i = 0; i < 8; i++) begin
            int er, ep, ev;
            @(negedge clk); map_idx = IW'(i); #1;
            if (i >= RC) begin er = 0; ep = 0; ev = 0; end
            else begin
                er = (i < 2) ? i : ((i % 2 == 0) ? 2 : 3);
                ep = (i < 2) ? 0 : (i - 2) / 2 + 1;
                ev = exp_vec(i);
            end
            check("R2 role", 64'(map_role), 64'(er));
            check("R2 port", 64'(map_port), 64'(ep));
            check("R3 vec", 64'(map_vec), 64'(ev));
        end
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); map_pnum = PW'(p); #1;
            check("R2 tx_idx", 64'(map_tx_idx), (p >= 1 && p <= NP) ? 64'((p - 1) * 2 + 2) : 0);
            check("R2 rx_idx", 64'(map_rx_idx), (p >= 1 && p <= NP) ? 64'((p - 1) * 2 + 3) : 0);
        end

        // R4: split base writes on every ring
        for (int r = 0; r < RC; r++) begin
            wr(adr(r, 0), 64'hFFFF_FFFF_A000_0000 + 64'(r), 1'b0);
            wr(adr(r, 4), 64'hFFFF_FFFF_1234_0000 + 64'(r), 1'b0);
            rd(adr(r, 0), 1'b0, v); check("R4 lo", v, 64'hA000_0000 + 64'(r));
            rd(adr(r, 4), 1'b0, v); check("R4 hi", v, 64'h1234_0000 + 64'(r));
            rd(adr(r, 0), 1'b1, v); check("R4 full", v, {32'h1234_0000 + 32'(r), 32'hA000_0000 + 32'(r)});
        end
        wr(adr(0, 0), 64'h0000_DEAD, 1'b0);
        rd(adr(0, 0), 1'b1, v); check("R4 lo-only keeps base", v, 64'h1234_0000_A000_0000);
        wr(adr(1, 4), 64'h77, 1'b0);
        rd(adr(1, 0), 1'b1, v); check("R4 shared latch", v, 64'h0000_0077_0000_DEAD);
        wr(adr(1, 4), 64'h88, 1'b0);
        rd(adr(1, 0), 1'b1, v); check("R4 latch cleared", v, 64'h0000_0088_0000_0000);
        wr(adr(0, 0), 64'h0F0E_0D0C_0B0A_0908, 1'b1);
        rd(adr(0, 0), 1'b1, v); check("R4 wide write", v, 64'h0F0E_0D0C_0B0A_0908);

        // R5: size and control
        for (int r = 0; r < RC; r++) begin
            wr(adr(r, 8), 64'hFFFF_0000_0000_0004 + 64'(r), 1'b0);
            rd(adr(r, 8), 1'b0, v); check("R5 size", v, 64'(4 + r));
            wr(adr(r, 20), 64'h50 + 64'(r), 1'b0);
            check("R5 ctrl out", 64'(ring_ctrl[r*8 +: 8]), 64'h50 + 64'(r));
            rd(adr(r, 20), 1'b0, v); check("R5 ctrl reads zero", v, 0);
        end

        // R6 / R3: head accept and reject at the size boundary
        for (int r = 0; r < RC; r++) begin
            wr(adr(r, 12), 64'(3 + r), 1'b0);
            check("R6 head pulse", 64'(head_pulse), 64'(1) << r);
            check("R6 irq", 64'(irq_req), 1);
            check("R3 irq vec", 64'(irq_vec), 64'(exp_vec(r)));
            wr(adr(r, 12), 64'(4 + r), 1'b0);
            check("R6 reject pulse", 64'(head_pulse), 0);
            check("R6 reject irq", 64'(irq_req), 0);
            rd(adr(r, 12), 1'b0, v); check("R6 head kept", v, 64'(3 + r));
        end

        // R8: tail wrap on ring 2 (size 6), tail read-only
        post(6'b000100, 5);
        rd(adr(2, 16), 1'b0, v); check("R8 tail 5", v, 5);
        post(6'b000100, 1);
        rd(adr(2, 16), 1'b0, v); check("R8 tail wrap", v, 0);
        rd(adr(2, 24), 1'b0, v); check("R8 credits 6", v, 6);
        wr(adr(2, 16), 64'd3, 1'b0);
        rd(adr(2, 16), 1'b0, v); check("R8 tail ignores write", v, 0);

        // R7: credit returns with saturation at zero
        wr(adr(2, 24), 64'd2, 1'b0);
        check("R7 cred pulse", 64'(cred_pulse), 64'b000100);
        check("R7 irq remain", 64'(irq_req), 1);
        check("R7 irq vec", 64'(irq_vec), 2);
        rd(adr(2, 24), 1'b0, v); check("R7 cred 4", v, 4);
        wr(adr(2, 24), 64'd4, 1'b0);
        check("R7 pulse at zero", 64'(cred_pulse), 64'b000100);
        check("R7 no irq at zero", 64'(irq_req), 0);
        wr(adr(2, 24), 64'd3, 1'b0);
        check("R7 no irq underflow", 64'(irq_req), 0);
        rd(adr(2, 24), 1'b0, v); check("R7 clamp zero", v, 0);

        // R8: credit saturation and tail wrap on ring 3 (size 7)
        post(6'b001000, 20);
        rd(adr(3, 24), 1'b0, v); check("R8 cred saturate", v, 15);
        rd(adr(3, 16), 1'b0, v); check("R8 tail mod size", v, 6);

        // R1: outside the window space
        wr(adr(RC, 8), 64'd9, 1'b0);
        check("R1 no irq outside", 64'(irq_req), 0);
        rd(adr(RC, 8), 1'b0, v); check("R1 read above", v, 0);
        rd(AW'(WBASE - 24), 1'b0, v); check("R1 read below", v, 0);
        rd(adr(0, 8), 1'b0, v); check("R1 no alias ring0", v, 4);

        // R11 / R9: wide accesses off offset 0
        wr(adr(0, 8), 64'd99, 1'b1);
        rd(adr(0, 8), 1'b0, v); check("R11 wide write ignored", v, 4);
        rd(adr(0, 8), 1'b1, v); check("R9 wide read zero", v, 0);
        rd(adr(0, 28), 1'b0, v); check("R9 unused offset", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule